// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the programmable state of a set of breakpoint/watchpoint triggers for a processor core. A single index register picks which trigger the control and data registers currently reach, so software sees a constant register footprint however many triggers are built. Each trigger holds a control word and a data word. The control word carries a fixed type code, a debug-ownership bit, and the writable fields that steer matching: compare select, timing, action, chaining, match mode, four privilege enables and the fetch, load and store enables.

The block does no address comparison itself. Toward the memory pipeline it drives three summary flags that say whether any trigger watches instruction fetch, loads or stores. It also drives a one-cycle request to flush the address translation cache after every accepted control write. A trigger whose ownership bit is set can only be rewritten while the core is in debug mode. The block outputs the ownership bit of the selected trigger.

All register accesses share one port: a write strobe, a 2-bit register code, write data, and read data that follows the code in the same cycle.

Top module: `dtrig_bank`

## Requirements
- R1: A write to the index register (code 0) takes effect only when the written value is below NUM_TRIG; otherwise the index keeps its old value. Reading code 0 returns the index zero-extended.
- R2: When the selected trigger's ownership bit (bit XLEN-5 of its control word) is 1 and `in_debug` is 0, writes to its control word (code 1) and data word (code 2) change nothing. `sel_owned` shows that bit for the selected trigger.
- R3: A control write with the fetch enable (bit 2) set stores timing (bit 18) as 0, whatever value was written there.
- R4: After reset the index is 0, every trigger reads the type code 2 in bits XLEN-1..XLEN-4, all writable fields and data words are 0, and the three watch flags are 0.
- R5: The data word (code 2) reads back what was last written to the selected trigger. The spare data register (code 3) always reads 0, and writing it has no effect.
- R6: In the cycle after each accepted control write, `watch_fetch`, `watch_load` and `watch_store` equal the OR over all triggers of the fetch (bit 2), load (bit 0) and store (bit 1) enables. The flags change at no other time.
- R7: The type field and the mask-limit field (bits XLEN-6..XLEN-11, value MASK_MAX) are read-only: writes leave them unchanged, and reads return them in place.
- R8: `flush_req` is high for exactly the cycle after each accepted control write. A control write blocked by R2 gives no pulse.
- R9: The writable control fields read back at these bit positions: load 0, store 1, fetch 2, user 3, supervisor 4, hypervisor 5, machine 6, match mode 10..7, chain 11, action 17..12, timing 18, select 19. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_debug | input | 1 | Core is in debug mode |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register code: 0 index, 1 control, 2 data, 3 spare data |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the register code on `csr_addr` |
| sel_owned | output | 1 | Ownership bit of the selected trigger |
| watch_fetch | output | 1 | Some trigger has the fetch enable set |
| watch_load | output | 1 | Some trigger has the load enable set |
| watch_store | output | 1 | Some trigger has the store enable set |
| flush_req | output | 1 | One-cycle translation flush request |

## Verification
The timing override and the summary-flag update both act on the same control write. One write that sets the fetch enable and the timing bit together must therefore store timing as 0 while raising `watch_fetch` and `flush_req` in the next cycle. The bench issues such a word and reads back the control register, checking that timing is clear and that the flag and the pulse arrive on the same edge. It also makes a protected write just after leaving debug mode, where the protection check and the flush logic meet. The bench then checks that the stored word, the data and the flags are unchanged and that no pulse appears.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

   typedef enum logic [1:0] {
      CSR_SEL   = 2'd0,
      CSR_CTRL  = 2'd1,
      CSR_DATA  = 2'd2,
      CSR_DATA3 = 2'd3
   } csr_reg_e;

   // fixed low positions of the writable control fields
   localparam int unsigned B_LD     = 0;
   localparam int unsigned B_ST     = 1;
   localparam int unsigned B_EXE    = 2;
   localparam int unsigned B_U      = 3;
   localparam int unsigned B_S      = 4;
   localparam int unsigned B_H      = 5;
   localparam int unsigned B_M      = 6;
   localparam int unsigned B_MATCH  = 7;
   localparam int unsigned W_MATCH  = 4;
   localparam int unsigned B_CHAIN  = 11;
   localparam int unsigned B_ACT    = 12;
   localparam int unsigned W_ACT    = 6;
   localparam int unsigned B_TIMING = 18;
   localparam int unsigned B_SELECT = 19;

   // read-only high fields
   localparam int unsigned W_TYPE    = 4;
   localparam int unsigned W_MASKMAX = 6;
   localparam logic [W_TYPE-1:0] TRIG_TYPE = 4'd2;

   typedef struct packed {
      logic               dmode;
      logic               select;
      logic               timing;
      logic [W_ACT-1:0]   action;
      logic               chain;
      logic [W_MATCH-1:0] match;
      logic               m;
      logic               h;
      logic               s;
      logic               u;
      logic               exe;
      logic               st;
      logic               ld;
   } trig_ctrl_t;

endpackage

// File: rtl/dtrig_slot.sv
module dtrig_slot
   import dtrig_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned MASK_MAX = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_ctrl,
   input  logic            wr_data,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] ctrl_rd,
   output logic [XLEN-1:0] data_rd,
   output logic            dmode,
   output logic            nxt_exe,
   output logic            nxt_ld,
   output logic            nxt_st
);

   localparam int unsigned B_DMODE = XLEN - W_TYPE - 1;
   localparam int unsigned B_MMAX  = B_DMODE - W_MASKMAX;
   localparam logic [W_MASKMAX-1:0] MMAX_VAL = W_MASKMAX'(MASK_MAX);

   trig_ctrl_t      ctrl_q;
   trig_ctrl_t      wr_c;
   logic [XLEN-1:0] data_q;

   // decode of an incoming control word
   always_comb begin
      wr_c        = '0;
      wr_c.dmode  = wdata[B_DMODE];
      wr_c.select = wdata[B_SELECT];
      wr_c.timing = wdata[B_EXE] ? 1'b0 : wdata[B_TIMING];
      wr_c.action = wdata[B_ACT +: W_ACT];
      wr_c.chain  = wdata[B_CHAIN];
      wr_c.match  = wdata[B_MATCH +: W_MATCH];
      wr_c.m      = wdata[B_M];
      wr_c.h      = wdata[B_H];
      wr_c.s      = wdata[B_S];
      wr_c.u      = wdata[B_U];
      wr_c.exe    = wdata[B_EXE];
      wr_c.st     = wdata[B_ST];
      wr_c.ld     = wdata[B_LD];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wr_c;
         if (wr_data) data_q <= wdata;
      end
   end

   // read view with the read-only fields placed
   always_comb begin
      ctrl_rd                          = '0;
      ctrl_rd[XLEN-1 -: W_TYPE]        = TRIG_TYPE;
      ctrl_rd[B_DMODE]                 = ctrl_q.dmode;
      ctrl_rd[B_MMAX +: W_MASKMAX]     = MMAX_VAL;
      ctrl_rd[B_SELECT]                = ctrl_q.select;
      ctrl_rd[B_TIMING]                = ctrl_q.timing;
      ctrl_rd[B_ACT +: W_ACT]          = ctrl_q.action;
      ctrl_rd[B_CHAIN]                 = ctrl_q.chain;
      ctrl_rd[B_MATCH +: W_MATCH]      = ctrl_q.match;
      ctrl_rd[B_M]                     = ctrl_q.m;
      ctrl_rd[B_H]                     = ctrl_q.h;
      ctrl_rd[B_S]                     = ctrl_q.s;
      ctrl_rd[B_U]                     = ctrl_q.u;
      ctrl_rd[B_EXE]                   = ctrl_q.exe;
      ctrl_rd[B_ST]                    = ctrl_q.st;
      ctrl_rd[B_LD]                    = ctrl_q.ld;
   end

   assign data_rd = data_q;
   assign dmode   = ctrl_q.dmode;
   assign nxt_exe = wr_ctrl ? wr_c.exe : ctrl_q.exe;
   assign nxt_ld  = wr_ctrl ? wr_c.ld  : ctrl_q.ld;
   assign nxt_st  = wr_ctrl ? wr_c.st  : ctrl_q.st;

   AST_EXE_CLEARS_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[B_EXE]) |=> !ctrl_rd[B_TIMING]); // R3

endmodule

// File: rtl/dtrig_watch.sv
module dtrig_watch #(
   parameter int unsigned NUM_TRIG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd,
   input  logic [NUM_TRIG-1:0] nxt_exe,
   input  logic [NUM_TRIG-1:0] nxt_ld,
   input  logic [NUM_TRIG-1:0] nxt_st,
   output logic                watch_fetch,
   output logic                watch_load,
   output logic                watch_store
);

   logic any_exe, any_ld, any_st;

   generate
      if (NUM_TRIG == 1) begin : g_single
         assign any_exe = nxt_exe[0];
         assign any_ld  = nxt_ld[0];
         assign any_st  = nxt_st[0];
      end else begin : g_multi
         assign any_exe = |nxt_exe;
         assign any_ld  = |nxt_ld;
         assign any_st  = |nxt_st;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         watch_fetch <= 1'b0;
         watch_load  <= 1'b0;
         watch_store <= 1'b0;
      end else if (upd) begin
         watch_fetch <= any_exe;
         watch_load  <= any_ld;
         watch_store <= any_st;
      end
   end

   AST_WATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable({watch_fetch, watch_load, watch_store})); // R6

endmodule

// File: rtl/dtrig_bank.sv
module dtrig_bank
   import dtrig_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NUM_TRIG = 4,
   parameter int unsigned MASK_MAX = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_debug,
   input  logic            csr_we,
   input  logic [1:0]      csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            sel_owned,
   output logic            watch_fetch,
   output logic            watch_load,
   output logic            watch_store,
   output logic            flush_req
);

   localparam int unsigned SELW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("dtrig_bank: XLEN must be 32 or 64");
      end
      if (NUM_TRIG < 1 || NUM_TRIG > 32) begin : g_bad_num
         $error("dtrig_bank: NUM_TRIG must be 1..32");
      end
      if (MASK_MAX >= (1 << W_MASKMAX)) begin : g_bad_mmax
         $error("dtrig_bank: MASK_MAX does not fit its field");
      end
   endgenerate

   csr_reg_e            reg_code;
   logic [SELW-1:0]     sel_q;
   logic                ctrl_ok;
   logic                sel_wr_ok;
   logic [NUM_TRIG-1:0] wr_ctrl_v, wr_data_v, dmode_v;
   logic [NUM_TRIG-1:0] nxt_exe_v, nxt_ld_v, nxt_st_v;
   logic [XLEN-1:0]     ctrl_rd_a [NUM_TRIG];
   logic [XLEN-1:0]     data_rd_a [NUM_TRIG];
   logic [XLEN-1:0]     sel_ctrl, sel_data;

   assign reg_code  = csr_reg_e'(csr_addr);
   assign ctrl_ok   = !sel_owned || in_debug;
   assign sel_wr_ok = csr_we && (reg_code == CSR_SEL)
                      && (csr_wdata < XLEN'(NUM_TRIG));

   // index register
   always_ff @(posedge clk) begin
      if (!rst_n)         sel_q <= '0;
      else if (sel_wr_ok) sel_q <= csr_wdata[SELW-1:0];
   end

   // per-trigger storage
   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
      assign wr_ctrl_v[i] = csr_we && (reg_code == CSR_CTRL) && ctrl_ok
                            && (sel_q == SELW'(i));
      assign wr_data_v[i] = csr_we && (reg_code == CSR_DATA) && ctrl_ok
                            && (sel_q == SELW'(i));
      dtrig_slot #(.XLEN(XLEN), .MASK_MAX(MASK_MAX)) i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (wr_ctrl_v[i]),
         .wr_data (wr_data_v[i]),
         .wdata   (csr_wdata),
         .ctrl_rd (ctrl_rd_a[i]),
         .data_rd (data_rd_a[i]),
         .dmode   (dmode_v[i]),
         .nxt_exe (nxt_exe_v[i]),
         .nxt_ld  (nxt_ld_v[i]),
         .nxt_st  (nxt_st_v[i])
      );
   end

   // selected-trigger view; an index with no trigger reads zero
   always_comb begin
      sel_ctrl  = '0;
      sel_data  = '0;
      sel_owned = 1'b0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         if (sel_q == SELW'(i)) begin
            sel_ctrl  = ctrl_rd_a[i];
            sel_data  = data_rd_a[i];
            sel_owned = dmode_v[i];
         end
      end
   end

   always_comb begin
      unique case (reg_code)
         CSR_SEL:   csr_rdata = XLEN'(sel_q);
         CSR_CTRL:  csr_rdata = sel_ctrl;
         CSR_DATA:  csr_rdata = sel_data;
         default:   csr_rdata = '0;
      endcase
   end

   dtrig_watch #(.NUM_TRIG(NUM_TRIG)) i_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd         (|wr_ctrl_v),
      .nxt_exe     (nxt_exe_v),
      .nxt_ld      (nxt_ld_v),
      .nxt_st      (nxt_st_v),
      .watch_fetch (watch_fetch),
      .watch_load  (watch_load),
      .watch_store (watch_store)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) flush_req <= 1'b0;
      else        flush_req <= |wr_ctrl_v;
   end

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sel_q) < NUM_TRIG); // R1
   AST_SEL_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && reg_code == CSR_SEL && csr_wdata >= XLEN'(NUM_TRIG))
      |=> $stable(sel_q)); // R1
   AST_BLOCKED_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && reg_code == CSR_CTRL && sel_owned && !in_debug)
      |=> !flush_req); // R2
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_code == CSR_DATA3) |-> (csr_rdata == '0)); // R5
   AST_LOAD_RISE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(watch_load) |-> flush_req); // R8

endmodule

// File: tb/test_dtrig_bank.sv
module test_dtrig_bank;

   localparam int unsigned XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_debug = 1'b0;
   logic            csr_we = 1'b0;
   logic [1:0]      csr_addr = 2'd0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic [XLEN-1:0] csr_rdata;
   logic            sel_owned, watch_fetch, watch_load, watch_store, flush_req;

   int checks = 0;
   int errors = 0;
   logic last_flush;

   localparam logic [31:0] RST_CTRL = 32'h2080_0000; // type 2, mask limit 4

   always #5 clk = ~clk;

   dtrig_bank #(.XLEN(XLEN), .NUM_TRIG(4), .MASK_MAX(4)) i_dtrig_bank (
      .clk(clk), .rst_n(rst_n), .in_debug(in_debug), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .sel_owned(sel_owned), .watch_fetch(watch_fetch),
      .watch_load(watch_load), .watch_store(watch_store),
      .flush_req(flush_req)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(posedge clk);
      #1 last_flush = flush_req;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); chk("R4 index", v, 0);
      chk("R4 watches", {29'd0, watch_fetch, watch_load, watch_store}, 0);
      chk("R4 flush", {31'd0, flush_req}, 0);
      for (int i = 0; i < 4; i++) begin
         wr(2'd0, i);
         rd(2'd1, v); chk("R4 R7 reset ctrl", v, RST_CTRL);
         rd(2'd2, v); chk("R4 reset data", v, 0);
      end
   endtask

   task automatic t_select();
      logic [31:0] v;
      wr(2'd0, 3); rd(2'd0, v); chk("R1 index 3", v, 3);
      wr(2'd0, 4); rd(2'd0, v); chk("R1 index 4 ignored", v, 3);
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R1 index max ignored", v, 3);
      wr(2'd0, 0); rd(2'd0, v); chk("R1 index 0", v, 0);
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(2'd1, 32'hF004_0043);
      chk("R8 pulse after write", {31'd0, last_flush}, 1);
      chk("R6 ld st set", {29'd0, watch_fetch, watch_load, watch_store}, 3'b011);
      @(posedge clk); #1 chk("R8 pulse one cycle", {31'd0, flush_req}, 0);
      rd(2'd1, v); chk("R7 R9 readback", v, 32'h2084_0043);
      wr(2'd1, 32'h000F_FFF8);
      rd(2'd1, v); chk("R9 all fields", v, 32'h208F_FFF8);
      chk("R6 recomputed clear", {29'd0, watch_fetch, watch_load, watch_store}, 0);
   endtask

   task automatic t_exe();
      logic [31:0] v;
      wr(2'd0, 2);
      wr(2'd1, 32'h0004_0004);
      chk("R3 R6 fetch flag", {31'd0, watch_fetch}, 1);
      chk("R8 pulse with fetch", {31'd0, last_flush}, 1);
      rd(2'd1, v); chk("R3 timing forced 0", v, 32'h2080_0004);
      wr(2'd0, 3);
      wr(2'd1, 32'h0000_0001);
      chk("R6 or over triggers", {29'd0, watch_fetch, watch_load, watch_store}, 3'b110);
   endtask

   task automatic t_data();
      logic [31:0] v;
      wr(2'd0, 1);
      wr(2'd2, 32'hDEAD_BEEF); rd(2'd2, v); chk("R5 data", v, 32'hDEAD_BEEF);
      wr(2'd3, 32'h1234_5678); rd(2'd3, v); chk("R5 spare zero", v, 0);
      rd(2'd2, v); chk("R5 data after spare write", v, 32'hDEAD_BEEF);
      chk("R5 spare no pulse", {31'd0, last_flush}, 0);
   endtask

   task automatic t_prot();
      logic [31:0] v;
      in_debug = 1'b1;
      wr(2'd1, 32'h0800_0002);
      rd(2'd1, v); chk("R2 owned write in debug", v, 32'h2880_0002);
      chk("R2 owned flag", {31'd0, sel_owned}, 1);
      in_debug = 1'b0;
      wr(2'd1, 32'h0000_0000);
      chk("R2 R8 blocked no pulse", {31'd0, last_flush}, 0);
      rd(2'd1, v); chk("R2 ctrl kept", v, 32'h2880_0002);
      chk("R2 watches kept", {29'd0, watch_fetch, watch_load, watch_store}, 3'b111);
      wr(2'd2, 32'h0000_0055);
      rd(2'd2, v); chk("R2 data kept", v, 32'hDEAD_BEEF);
      in_debug = 1'b1;
      wr(2'd1, 32'h0000_0000);
      rd(2'd1, v); chk("R2 debug clears", v, RST_CTRL);
      chk("R2 owned flag cleared", {31'd0, sel_owned}, 0);
      in_debug = 1'b0;
   endtask

   task automatic t_clear();
      wr(2'd0, 2); wr(2'd1, 0);
      chk("R6 fetch dropped", {29'd0, watch_fetch, watch_load, watch_store}, 3'b010);
      wr(2'd0, 3); wr(2'd1, 0);
      chk("R6 all dropped", {29'd0, watch_fetch, watch_load, watch_store}, 0);
   endtask

   initial begin
      #100000000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_select();
      t_ctrl();
      t_exe();
      t_data();
      t_prot();
      t_clear();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule